// File: doc/BRIEF.md
# PCI Bus Stall Interrupt Monitor

This block sits beside a PCI bus arbiter and watches the shared bus control lines for participants that stop making progress. It samples the grant to the pending master, FRAME#, IRDY#, TRDY#, STOP# and PERR# on every rising clock edge. Cycle counters run only during the bus phases in which a specific response is awaited. When a counter reaches its limit, the block sets a sticky flag in a 32-bit interrupt status register.

Software reads the status register and a companion mask register through a small register port. It clears flags by writing ones to them. A single interrupt line is the OR of every flag that is both set and enabled in the mask. Two side inputs tell the block how to judge parity errors. One says whether this controller mastered the current transaction. The other says whether that transaction is a write.

Top module: `pci_stall_irq`

## Requirements
- R1: While the grant is asserted and the bus is idle (FRAME# and IRDY# both high), the status bit at position 13 is set on the 16th consecutive sampled cycle, and is still clear after 15.
- R2: Before any data transfer has completed in the current transaction, the status bit at position 12 is set when 16 consecutive busy cycles (FRAME# or IRDY# low) are sampled with TRDY# and STOP# both high.
- R3: Once a transfer (IRDY# and TRDY# both low) has been sampled since the bus left idle, the same bit 12 limit becomes 8 consecutive cycles.
- R4: The status bit at position 11 is set on the 8th consecutive sampled cycle with FRAME# low and IRDY# high.
- R5: The status bit at position 1 is set in the cycle after PERR# is sampled low while the write input is high and the local-master input is low. It is not set while the local-master input is high.
- R6: A high level on the synchronous reset or on the software reset input clears the status register, the mask register and all counters.
- R7: Status bits are sticky. A register write with address 0 clears each bit written as 1. A detection in the same cycle as its clear leaves the bit set.
- R8: Address 1 holds the mask register, and only bits 13, 12, 11 and 1 are stored. All other bits of both registers read 0. The irq output is high exactly when some status bit and the same mask bit are both 1.
- R9: After a counter fires, it cannot fire again until its phase ends. For bit 13 the phase ends when the grant is removed or FRAME# goes low. For bits 12 and 11 it ends when the bus returns to idle.
- R10: Each counter restarts from zero when its awaited event is sampled. For bit 12 that event is TRDY# or STOP# low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous power-on reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| gnt_n | input | 1 | Grant to the pending master, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | IRDY#, active low |
| trdy_n | input | 1 | TRDY#, active low |
| stop_n | input | 1 | STOP#, active low |
| perr_n | input | 1 | PERR#, active low |
| local_mst | input | 1 | High when this controller masters the current transaction |
| wr_dir | input | 1 | High when the current transaction is a write |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Combined masked interrupt |

## Verification
A software clear of a status bit can land in the same cycle as a new detection of that bit. The bench provokes this directly by holding PERR# low through a write-one-to-clear of bit 1 and expects the bit to survive. Randomly timed clear writes also collide with timer expiries and parity errors during long held bus patterns. A cycle model in the bench decides each outcome, and it always favours the new detection.

// File: rtl/pci_stall_pkg.sv
package pci_stall_pkg;

    localparam int STAT_W        = 32;
    localparam int POS_MST_BROKE = 13;
    localparam int POS_TGT_TMO   = 12;
    localparam int POS_MST_TMO   = 11;
    localparam int POS_WR_PERR   = 1;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

    // bus lines translated to active-high meaning
    typedef struct packed {
        logic gnt;
        logic frame;
        logic irdy;
        logic trdy;
        logic stop;
        logic perr;
    } bus_t;

    typedef struct packed {
        logic mst_broke;
        logic tgt_tmo;
        logic mst_tmo;
        logic wr_perr;
    } det_t;

    function automatic logic [STAT_W-1:0] impl_bits();
        logic [STAT_W-1:0] v;
        v = '0;
        v[POS_MST_BROKE] = 1'b1;
        v[POS_TGT_TMO]   = 1'b1;
        v[POS_MST_TMO]   = 1'b1;
        v[POS_WR_PERR]   = 1'b1;
        return v;
    endfunction

    function automatic logic [STAT_W-1:0] det_to_vec(det_t d);
        logic [STAT_W-1:0] v;
        v = '0;
        v[POS_MST_BROKE] = d.mst_broke;
        v[POS_TGT_TMO]   = d.tgt_tmo;
        v[POS_MST_TMO]   = d.mst_tmo;
        v[POS_WR_PERR]   = d.wr_perr;
        return v;
    endfunction

endpackage

// File: rtl/pci_stall_timer.sv
module pci_stall_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          run,
    input  logic          rearm,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    logic [CW-1:0] cnt_q;
    logic          spent_q;

    assign fire = run && !spent_q && (cnt_q == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q   <= '0;
            spent_q <= 1'b0;
        end else begin
            if (!run || spent_q || fire) cnt_q <= '0;
            else                         cnt_q <= cnt_q + CW'(1);
            if (fire)       spent_q <= 1'b1;
            else if (rearm) spent_q <= 1'b0;
        end
    end
endmodule

// File: rtl/pci_phase_track.sv
module pci_phase_track
    import pci_stall_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  bus_t bus,
    output logic bus_idle,
    output logic later_phase,
    output logic run_broke,
    output logic rearm_broke,
    output logic run_tgt,
    output logic run_mst
);
    logic xfer_seen_q;

    assign bus_idle    = !bus.frame && !bus.irdy;
    assign later_phase = xfer_seen_q;
    assign run_broke   = bus.gnt && bus_idle;
    assign rearm_broke = !bus.gnt || bus.frame;
    assign run_tgt     = !bus_idle && !bus.trdy && !bus.stop;
    assign run_mst     = bus.frame && !bus.irdy;

    always_ff @(posedge clk) begin
        if (clr || bus_idle)         xfer_seen_q <= 1'b0;
        else if (bus.irdy && bus.trdy) xfer_seen_q <= 1'b1;
    end
endmodule

// File: rtl/pci_irq_regs.sv
module pci_irq_regs
    import pci_stall_pkg::*;
(
    input  logic              clk,
    input  logic              clr,
    input  det_t              det,
    input  logic              reg_wr,
    input  reg_sel_e          sel,
    input  logic [STAT_W-1:0] wdata,
    output logic [STAT_W-1:0] st_q,
    output logic [STAT_W-1:0] mask_q,
    output logic [STAT_W-1:0] rdata,
    output logic              irq
);
    localparam logic [STAT_W-1:0] IMPL = impl_bits();

    logic [STAT_W-1:0] wipe;

    assign wipe  = (reg_wr && sel == SEL_STATUS) ? wdata : '0;
    assign rdata = (sel == SEL_MASK) ? mask_q : st_q;
    assign irq   = |(st_q & mask_q);

    always_ff @(posedge clk) begin
        if (clr) begin
            st_q   <= '0;
            mask_q <= '0;
        end else begin
            st_q <= ((st_q & ~wipe) | det_to_vec(det)) & IMPL;
            if (reg_wr && sel == SEL_MASK) mask_q <= wdata & IMPL;
        end
    end
endmodule

// File: rtl/pci_stall_irq.sv
module pci_stall_irq
    import pci_stall_pkg::*;
#(
    parameter int BROKE_CYC = 16,
    parameter int TGT_FIRST = 16,
    parameter int TGT_NEXT  = 8,
    parameter int MST_CYC   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_rst,
    input  logic        gnt_n,
    input  logic        frame_n,
    input  logic        irdy_n,
    input  logic        trdy_n,
    input  logic        stop_n,
    input  logic        perr_n,
    input  logic        local_mst,
    input  logic        wr_dir,
    input  logic        reg_wr,
    input  logic        reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int MAX_A = (BROKE_CYC > TGT_FIRST) ? BROKE_CYC : TGT_FIRST;
    localparam int MAX_B = (TGT_NEXT > MST_CYC) ? TGT_NEXT : MST_CYC;
    localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_L + 1);
    localparam int NT    = 3;

    logic clr;
    bus_t bus;
    det_t det;
    logic bus_idle, later_phase, run_broke, rearm_broke, run_tgt, run_mst;
    logic [NT-1:0] t_run, t_rearm, t_fire;
    logic [CW-1:0] t_lim [NT];
    logic [STAT_W-1:0] st_q, mask_q;

    assign clr = rst || sw_rst;
    assign bus = '{gnt: !gnt_n, frame: !frame_n, irdy: !irdy_n,
                   trdy: !trdy_n, stop: !stop_n, perr: !perr_n};

    pci_phase_track u_track (
        .clk(clk), .clr(clr), .bus(bus),
        .bus_idle(bus_idle), .later_phase(later_phase),
        .run_broke(run_broke), .rearm_broke(rearm_broke),
        .run_tgt(run_tgt), .run_mst(run_mst)
    );

    // timer 0: grant without FRAME#, 1: target response, 2: master ready
    assign t_run   = {run_mst, run_tgt, run_broke};
    assign t_rearm = {bus_idle, bus_idle, rearm_broke};
    assign t_lim[0] = CW'(BROKE_CYC);
    assign t_lim[1] = later_phase ? CW'(TGT_NEXT) : CW'(TGT_FIRST);
    assign t_lim[2] = CW'(MST_CYC);

    for (genvar i = 0; i < NT; i++) begin : g_tmr
        pci_stall_timer #(.CW(CW)) u_tmr (
            .clk(clk), .clr(clr), .run(t_run[i]), .rearm(t_rearm[i]),
            .limit(t_lim[i]), .fire(t_fire[i])
        );
    end

    assign det.mst_broke = t_fire[0];
    assign det.tgt_tmo   = t_fire[1];
    assign det.mst_tmo   = t_fire[2];
    assign det.wr_perr   = bus.perr && wr_dir && !local_mst;

    pci_irq_regs u_regs (
        .clk(clk), .clr(clr), .det(det), .reg_wr(reg_wr),
        .sel(reg_sel_e'(reg_addr)), .wdata(reg_wdata),
        .st_q(st_q), .mask_q(mask_q), .rdata(reg_rdata), .irq(irq)
    );
endmodule

// File: rtl/pci_stall_irq_chk.sv
module pci_stall_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        sw_rst,
    input logic        gnt_n,
    input logic        frame_n,
    input logic        irdy_n,
    input logic        trdy_n,
    input logic        stop_n,
    input logic        perr_n,
    input logic        local_mst,
    input logic        wr_dir,
    input logic        reg_wr,
    input logic        reg_addr,
    input logic [31:0] st_q,
    input logic [31:0] mask_q,
    input logic        irq
);
    AST_SWRST_CLEARS: assert property (@(posedge clk)
        sw_rst |=> (st_q == 32'h0 && mask_q == 32'h0)); // R6

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!sw_rst && !(reg_wr && !reg_addr)) |=> ((st_q & $past(st_q)) == $past(st_q))); // R7

    AST_PERR_SETS: assert property (@(posedge clk) disable iff (rst)
        (!perr_n && wr_dir && !local_mst && !sw_rst) |=> st_q[1]); // R5

    AST_BROKE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q[13]) |-> $past(!gnt_n && frame_n && irdy_n)); // R1

    AST_TGT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q[12]) |-> $past(trdy_n && stop_n && !(frame_n && irdy_n))); // R2

    AST_MST_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q[11]) |-> $past(!frame_n && irdy_n)); // R4

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (mask_q == 32'h0) |-> !irq); // R8
endmodule

bind pci_stall_irq pci_stall_irq_chk u_chk (
    .clk(clk), .rst(rst), .sw_rst(sw_rst), .gnt_n(gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n),
    .local_mst(local_mst), .wr_dir(wr_dir), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .st_q(st_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/pci_stall_irq_tb.sv
`timescale 1ns/1ps
module pci_stall_irq_tb;
    localparam logic [31:0] IMPL = 32'h0000_3802;

    logic clk = 1'b0;
    logic rst = 1'b1, sw_rst = 1'b0;
    logic gnt_n = 1'b1, frame_n = 1'b1, irdy_n = 1'b1, trdy_n = 1'b1;
    logic stop_n = 1'b1, perr_n = 1'b1, local_mst = 1'b0, wr_dir = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic irq;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pci_stall_irq u_dut (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .gnt_n(gnt_n), .frame_n(frame_n),
        .irdy_n(irdy_n), .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n),
        .local_mst(local_mst), .wr_dir(wr_dir), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    // cycle model built from the requirements
    logic [31:0] m_st = 0, m_mask = 0;
    int mb_c = 0, tt_c = 0, mt_c = 0;
    bit mb_s = 0, tt_s = 0, mt_s = 0, m_done = 0;

    always @(posedge clk) begin
        bit idle;
        logic [31:0] setv, wipe;
        int tl;
        idle = frame_n && irdy_n;
        if (rst || sw_rst) begin
            m_st = 0; m_mask = 0; mb_c = 0; tt_c = 0; mt_c = 0;
            mb_s = 0; tt_s = 0; mt_s = 0; m_done = 0;
        end else begin
            setv = 0;
            if (!(!gnt_n && idle)) mb_c = 0;
            else if (!mb_s) begin
                if (mb_c == 15) begin setv[13] = 1; mb_s = 1; mb_c = 0; end
                else mb_c++;
            end
            if (gnt_n || !frame_n) mb_s = 0;
            tl = m_done ? 8 : 16;
            if (!(!idle && trdy_n && stop_n)) tt_c = 0;
            else if (!tt_s) begin
                if (tt_c == tl - 1) begin setv[12] = 1; tt_s = 1; tt_c = 0; end
                else tt_c++;
            end
            if (idle) tt_s = 0;
            if (!(!frame_n && irdy_n)) mt_c = 0;
            else if (!mt_s) begin
                if (mt_c == 7) begin setv[11] = 1; mt_s = 1; mt_c = 0; end
                else mt_c++;
            end
            if (idle) mt_s = 0;
            if (idle) m_done = 0;
            else if (!irdy_n && !trdy_n) m_done = 1;
            if (!perr_n && wr_dir && !local_mst) setv[1] = 1;
            wipe = (reg_wr && !reg_addr) ? reg_wdata : 32'h0;
            m_st = ((m_st & ~wipe) | setv) & IMPL;
            if (reg_wr && reg_addr) m_mask = reg_wdata & IMPL;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic a, logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 0; reg_addr = 0;
    endtask

    task automatic go_idle();
        gnt_n = 1; frame_n = 1; irdy_n = 1; trdy_n = 1; stop_n = 1; perr_n = 1;
        tick(1);
        wr(0, 32'hFFFF_FFFF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(3);
        rst = 0;
        chk("R6 reset status", reg_rdata, 0);
        chk("R6 reset irq", {31'h0, irq}, 0);

        // R1 boundary 15 vs 16
        gnt_n = 0;
        tick(15); chk("R1 no flag after 15", reg_rdata & 32'h2000, 0);
        tick(1);  chk("R1 flag after 16", reg_rdata & 32'h2000, 32'h2000);
        // R9 no re-fire while stall continues
        wr(0, 32'h2000);
        tick(25); chk("R9 no second flag", reg_rdata & 32'h2000, 0);
        gnt_n = 1; tick(1); gnt_n = 0;
        tick(16); chk("R9 rearmed after grant drop", reg_rdata & 32'h2000, 32'h2000);
        go_idle();

        // R2 first phase, 16 cycles
        frame_n = 0; irdy_n = 0;
        tick(15); chk("R2 no flag after 15", reg_rdata & 32'h1000, 0);
        tick(1);  chk("R2 flag after 16", reg_rdata & 32'h1000, 32'h1000);
        go_idle();

        // R3 later phase, 8 cycles
        frame_n = 0; irdy_n = 0; trdy_n = 0;
        tick(1); trdy_n = 1;
        tick(7); chk("R3 no flag after 7", reg_rdata & 32'h1000, 0);
        tick(1); chk("R3 flag after 8", reg_rdata & 32'h1000, 32'h1000);
        go_idle();

        // R10 restart on STOP#
        frame_n = 0; irdy_n = 0;
        tick(12); stop_n = 0; tick(1); stop_n = 1;
        tick(12); chk("R10 counter restarted", reg_rdata & 32'h1000, 0);
        go_idle();

        // R4 master ready, 8 cycles
        frame_n = 0; irdy_n = 1;
        tick(7); chk("R4 no flag after 7", reg_rdata & 32'h0800, 0);
        tick(1); chk("R4 flag after 8", reg_rdata & 32'h1800, 32'h0800);
        go_idle();

        // R5 parity error
        perr_n = 0; wr_dir = 1; local_mst = 1;
        tick(1); chk("R5 ignored when local master", reg_rdata & 32'h2, 0);
        local_mst = 0;
        tick(1); chk("R5 set for other master", reg_rdata & 32'h2, 32'h2);

        // R7 set beats clear (PERR# still low)
        wr(0, 32'h2);
        chk("R7 detection wins over clear", reg_rdata & 32'h2, 32'h2);
        perr_n = 1; tick(1);
        wr(0, 32'h2);
        chk("R7 clear by write one", reg_rdata, 0);

        // R8 mask and irq
        perr_n = 0; tick(1); perr_n = 1;
        wr(1, 32'hFFFF_FFFF);
        reg_addr = 1; tick(0); #1;
        chk("R8 mask implemented bits", reg_rdata, IMPL);
        reg_addr = 0; #1;
        chk("R8 irq with enabled bit", {31'h0, irq}, 1);
        wr(1, 32'h2000);
        chk("R8 irq masked off", {31'h0, irq}, 0);

        // R6 software reset
        sw_rst = 1; tick(1); sw_rst = 0;
        chk("R6 sw reset status", reg_rdata, 0);
        reg_addr = 1; #1;
        chk("R6 sw reset mask", reg_rdata, 0);
        reg_addr = 0;
        tick(1);

        // random phase against the model
        begin
            int hold = 0;
            for (int i = 0; i < 6000; i++) begin
                int r;
                chk("R1-model status", reg_rdata, reg_addr ? m_mask : m_st);
                chk("R8 model irq", {31'h0, irq}, {31'h0, |(m_st & m_mask)});
                if (hold == 0) begin
                    gnt_n = 1'($urandom % 2);
                    frame_n = 1'($urandom % 2);
                    irdy_n = 1'($urandom % 2);
                    trdy_n = ($urandom % 4) != 0;
                    stop_n = ($urandom % 8) != 0;
                    perr_n = ($urandom % 16) != 0;
                    wr_dir = 1'($urandom % 2);
                    local_mst = 1'($urandom % 2);
                    hold = 1 + int'($urandom % 24);
                end
                hold--;
                r = int'($urandom % 32);
                reg_wr = (r < 3);
                reg_addr = (r == 2);
                reg_wdata = $urandom;
                sw_rst = ($urandom % 700) == 0;
                tick(1);
            end
        end
        finish_run();
    end
endmodule